// File: doc/BRIEF.md
# Configurable Data Unit

A small sequential engine built around one working register. An opcode selects what the register does: it can count up or down and stop at a limit, count and reload, rotate right, shift right with a serial input bit, test itself bitwise against an operand, or shift while comparing against a majority-of-three pattern set or against an operand. The result is a single output bit. The unit is meant to sit in a port-level logic fabric, where other logic drives its three trigger lines and its two operands.

Three active-high triggers drive the register. Trigger 0 always loads the register with the load operand and beats the other two. Trigger 1 is the main step enable. Trigger 2 is either the down-count enable or the serial bit for shifts, depending on the opcode. A size input limits every operation to the low 1 to 8 bits: it sets the wrap points, the bit position a shift fills, and the width over which values are compared.

Top module: `cfg_data_unit`

## Requirements
- R1: While reset is asserted and after it is released, the working register reads zero, so with opcode 1 (decrement) the output is 1.
- R2: A high trig0 loads the register with data0 (masked to the size) at the next clock edge for every opcode, whatever trig1 and trig2 do; with all triggers low the register holds.
- R3: Opcode 0 (increment) counts up by one on each clock with trig1 high and stops once the register equals data1; the output is 1 while the register equals data1.
- R4: Opcode 1 (decrement) counts down by one on each clock with trig1 high and stops at 0; the output is 1 while the register is 0.
- R5: Opcode 2 (increment-wrap) reloads data0 on a trig1 step taken while the register equals data1, and opcode 3 (decrement-wrap) reloads data0 on a trig1 step taken at 0; the output is 1 while the register equals the terminal value, so with trig1 held it is a one-cycle pulse.
- R6: Opcode 4 (up/down) counts up with only trig1 high, down with only trig2 high, holds with both high, stops at data1 going up and at 0 going down; opcode 5 is the same but reloads data0 at those terminals; in both the output is 1 when the register equals data1 or 0.
- R7: Opcode 6 (rotate right) moves the register right by one on each trig1 step and puts the old bit 0 into bit size-1; the output is bit 0.
- R8: Opcode 7 (shift right) moves the register right by one on each trig1 step and puts trig2 into bit size-1; the output is bit 0.
- R9: Opcode 8 outputs 1 when (register AND data1) is nonzero; opcode 9 outputs 1 when (register OR data1) is nonzero; trig1 and trig2 leave the register unchanged.
- R10: Opcode 10 shifts as in R8 and outputs 1 when the register equals 3, 5, 6 or 7.
- R11: Opcode 11 shifts as in R8 and outputs 1 when the register equals data1.
- R12: size_sel from 1 to 8 sets the operation width; 0 and values above 8 mean 8; operand and register bits at or above the width take no part in any result or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_sel | input | 4 | Opcode, encoded as in the requirements |
| size_sel | input | 4 | Operation width in bits |
| trig0 | input | 1 | Load trigger |
| trig1 | input | 1 | Step / up-count trigger |
| trig2 | input | 1 | Down-count trigger or shift-in bit |
| data0 | input | 8 | Load operand |
| data1 | input | 8 | Limit / compare operand |
| du_out | output | 1 | Result bit |

## Verification
The assertions watch, on every cycle, the load priority of trig0, the hold with no trigger, the stop points of the one-shot counters, the hold when both up/down triggers are high, and the reload at the increment-wrap terminal. The output values of each opcode, the rotate and shift fill position at reduced sizes, the majority pattern set and the handling of out-of-range size codes can only be seen in the bench's scenarios, where a scoreboard predicts the output for each clock from the requirements.

// File: rtl/cdu_pkg.sv
package cdu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_INC       = 4'd0,
    OP_DEC       = 4'd1,
    OP_INC_WRAP  = 4'd2,
    OP_DEC_WRAP  = 4'd3,
    OP_UPDN      = 4'd4,
    OP_UPDN_WRAP = 4'd5,
    OP_ROR       = 4'd6,
    OP_SHR       = 4'd7,
    OP_AND       = 4'd8,
    OP_OR        = 4'd9,
    OP_SHR_MAJ   = 4'd10,
    OP_SHR_CMP   = 4'd11
  } op_e;
endpackage

// File: rtl/cdu_size_mask.sv
module cdu_size_mask #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic [SW-1:0] size_sel,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  msb
);
  logic [SW-1:0] eff;

  // Out-of-range codes fall back to full width
  always_comb begin
    if (size_sel == '0 || size_sel > SW'(W)) eff = SW'(W);
    else                                     eff = size_sel;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = (SW'(i) < eff);
    assign msb[i]  = (SW'(i + 1) == eff);
  end
endmodule

// File: rtl/cdu_next_state.sv
module cdu_next_state
  import cdu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic         t0,
  input  logic         t1,
  input  logic         t2,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] d0m,
  input  logic [W-1:0] d1m,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] msb,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] up, dn, shr_v, ror_v, raw;
  logic         at_top, at_zero, up_only, dn_only;

  always_comb begin
    up      = (cur + ONE) & mask;
    dn      = (cur - ONE) & mask;
    at_top  = (cur == d1m);
    at_zero = (cur == '0);
    shr_v   = (cur >> 1) | (t2 ? msb : '0);
    ror_v   = (cur >> 1) | (cur[0] ? msb : '0);
    up_only = t1 & ~t2;
    dn_only = t2 & ~t1;
  end

  always_comb begin
    raw = cur;
    if (t0) begin
      raw = d0m;
    end else begin
      case (op)
        OP_INC:       if (t1 && !at_top)  raw = up;
        OP_DEC:       if (t1 && !at_zero) raw = dn;
        OP_INC_WRAP:  if (t1) raw = at_top  ? d0m : up;
        OP_DEC_WRAP:  if (t1) raw = at_zero ? d0m : dn;
        OP_UPDN: begin
          if (up_only && !at_top)       raw = up;
          else if (dn_only && !at_zero) raw = dn;
        end
        OP_UPDN_WRAP: begin
          if (up_only)      raw = at_top  ? d0m : up;
          else if (dn_only) raw = at_zero ? d0m : dn;
        end
        OP_ROR:                         if (t1) raw = ror_v;
        OP_SHR, OP_SHR_MAJ, OP_SHR_CMP: if (t1) raw = shr_v;
        default:                        raw = cur;
      endcase
    end
    nxt = raw & mask;
  end
endmodule

// File: rtl/cdu_out_gen.sv
module cdu_out_gen
  import cdu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] d1m,
  output logic         res
);
  logic eq_top, eq_zero, maj3;

  always_comb begin
    eq_top  = (cur == d1m);
    eq_zero = (cur == '0);
    maj3    = (cur == W'(3)) || (cur == W'(5)) || (cur == W'(6)) || (cur == W'(7));
    case (op)
      OP_INC, OP_INC_WRAP, OP_SHR_CMP: res = eq_top;
      OP_DEC, OP_DEC_WRAP:             res = eq_zero;
      OP_UPDN, OP_UPDN_WRAP:           res = eq_top | eq_zero;
      OP_ROR, OP_SHR:                  res = cur[0];
      OP_AND:                          res = |(cur & d1m);
      OP_OR:                           res = |(cur | d1m);
      OP_SHR_MAJ:                      res = maj3;
      default:                         res = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_data_unit.sv
module cfg_data_unit
  import cdu_pkg::*;
#(
  parameter int  W  = 8,
  localparam int SW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_sel,
  input  logic [SW-1:0]   size_sel,
  input  logic            trig0,
  input  logic            trig1,
  input  logic            trig2,
  input  logic [W-1:0]    data0,
  input  logic [W-1:0]    data1,
  output logic            du_out
);
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic [W-1:0] mask, msb;
  logic [W-1:0] work_q, work_d, work_m, d0_m, d1_m;
  logic         step_en;
  op_e          op;

  // Reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign op      = op_e'(op_sel);
  assign d0_m    = data0 & mask;
  assign d1_m    = data1 & mask;
  assign work_m  = work_q & mask;
  assign step_en = trig0 | trig1 | trig2;

  cdu_size_mask #(.W(W), .SW(SW)) u_size (
    .size_sel (size_sel),
    .mask     (mask),
    .msb      (msb)
  );

  cdu_next_state #(.W(W)) u_next (
    .op   (op),
    .t0   (trig0),
    .t1   (trig1),
    .t2   (trig2),
    .cur  (work_m),
    .d0m  (d0_m),
    .d1m  (d1_m),
    .mask (mask),
    .msb  (msb),
    .nxt  (work_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  work_q <= '0;
    else if (step_en) work_q <= work_d;
  end

  cdu_out_gen #(.W(W)) u_out (
    .op  (op),
    .cur (work_m),
    .d1m (d1_m),
    .res (du_out)
  );

  a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig0 |=> (work_q == $past(d0_m)));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(trig0 || trig1 || trig2) |=> $stable(work_q));

  a_r3_inc_stops: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_INC && !trig0 && trig1 && work_m == d1_m) |=> (work_q == $past(work_m)));

  a_r4_dec_stops: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_DEC && !trig0 && trig1 && work_m == '0) |=> (work_q == '0));

  a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_INC_WRAP && !trig0 && trig1 && work_m == d1_m) |=> (work_q == $past(d0_m)));

  a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_UPDN && !trig0 && trig1 && trig2) |=> (work_q == $past(work_m)));
endmodule

// File: tb/test_cfg_data_unit.sv
`timescale 1ns/1ps
module test_cfg_data_unit;
  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_sel, size_sel;
  logic       trig0, trig1, trig2;
  logic [7:0] data0, data1;
  logic       du_out;

  item_t exp_q[$];
  item_t cur_item;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  int    m_reg  = 0;

  always #2.5 clk = ~clk;

  cfg_data_unit i_cfg_data_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .size_sel(size_sel),
    .trig0(trig0), .trig1(trig1), .trig2(trig2),
    .data0(data0), .data1(data1), .du_out(du_out)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: du_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference prediction written from the requirement text
  task automatic step(input int op, input int sz, input bit t0, input bit t1,
                      input bit t2, input int d0, input int d1, input string tag);
    int se, mk, top, r, a, b, nr;
    bit e;
    @(negedge clk);
    op_sel = 4'(op); size_sel = 4'(sz);
    trig0 = t0; trig1 = t1; trig2 = t2;
    data0 = 8'(d0); data1 = 8'(d1);
    se  = (sz == 0 || sz > 8) ? 8 : sz;
    mk  = (1 << se) - 1;
    top = 1 << (se - 1);
    r = m_reg & mk; a = d0 & mk; b = d1 & mk;
    if (t0 || t1 || t2) begin
      nr = r;
      if (t0) nr = a;
      else if (op == 0 && t1 && r != b) nr = r + 1;
      else if (op == 1 && t1 && r != 0) nr = r - 1;
      else if (op == 2 && t1) nr = (r == b) ? a : r + 1;
      else if (op == 3 && t1) nr = (r == 0) ? a : r - 1;
      else if ((op == 4 || op == 5) && t1 && !t2) nr = (r == b) ? ((op == 5) ? a : r) : r + 1;
      else if ((op == 4 || op == 5) && t2 && !t1) nr = (r == 0) ? ((op == 5) ? a : r) : r - 1;
      else if (op == 6 && t1) nr = (r >> 1) + ((r % 2) * top);
      else if ((op == 7 || op == 10 || op == 11) && t1) nr = (r >> 1) + (t2 ? top : 0);
      m_reg = nr & mk;
    end
    r = m_reg & mk;
    case (op)
      0, 2, 11: e = (r == b);
      1, 3:     e = (r == 0);
      4, 5:     e = (r == b) || (r == 0);
      6, 7:     e = r[0];
      8:        e = (r & b) != 0;
      9:        e = (r | b) != 0;
      10:       e = (r == 3) || (r == 5) || (r == 6) || (r == 7);
      default:  e = 1'b0;
    endcase
    exp_q.push_back('{exp: e, tag: tag});
    @(posedge clk);
  endtask

  // Monitor: compare one item per clock, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        cur_item = exp_q.pop_front();
        chk(du_out, cur_item.exp, cur_item.tag);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: expected=finish actual=hung");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_sel = 4'd1; size_sel = 4'd8;
    trig0 = 0; trig1 = 0; trig2 = 0; data0 = 8'h00; data1 = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(du_out, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(du_out, 1'b1, "R1 after reset");

    // R2: load wins over step triggers, then idle holds
    step(11, 8, 1, 1, 1, 8'h05, 8'h05, "R2");
    step(11, 8, 0, 0, 0, 8'h33, 8'h05, "R2");
    step(0, 8, 1, 1, 0, 8'h10, 8'h10, "R2");

    // R3: one-shot up count stopping at data1
    step(0, 8, 1, 0, 0, 250, 253, "R3");
    for (int i = 0; i < 5; i++) step(0, 8, 0, 1, 0, 250, 253, "R3");

    // R4: one-shot down count stopping at 0
    step(1, 8, 1, 0, 0, 3, 0, "R4");
    for (int i = 0; i < 5; i++) step(1, 8, 0, 1, 0, 3, 0, "R4");

    // R5: wrapping counters
    step(2, 8, 1, 0, 0, 1, 3, "R5");
    for (int i = 0; i < 7; i++) step(2, 8, 0, 1, 0, 1, 3, "R5");
    step(3, 8, 1, 0, 0, 2, 0, "R5");
    for (int i = 0; i < 6; i++) step(3, 8, 0, 1, 0, 2, 0, "R5");

    // R6: up/down, both-high hold, terminals, wrapping variant
    step(4, 8, 1, 0, 0, 2, 4, "R6");
    for (int i = 0; i < 3; i++) step(4, 8, 0, 1, 0, 2, 4, "R6");
    step(4, 8, 0, 1, 1, 2, 4, "R6");
    for (int i = 0; i < 6; i++) step(4, 8, 0, 0, 1, 2, 4, "R6");
    step(5, 8, 1, 0, 0, 2, 4, "R6");
    for (int i = 0; i < 4; i++) step(5, 8, 0, 1, 0, 2, 4, "R6");
    for (int i = 0; i < 4; i++) step(5, 8, 0, 0, 1, 2, 4, "R6");

    // R7: rotate at size 4
    step(6, 4, 1, 0, 0, 8'b0011, 0, "R7");
    for (int i = 0; i < 5; i++) step(6, 4, 0, 1, 0, 0, 0, "R7");

    // R8: shift at size 3 with a serial pattern
    step(7, 3, 1, 0, 0, 0, 0, "R8");
    step(7, 3, 0, 1, 1, 0, 0, "R8");
    step(7, 3, 0, 1, 0, 0, 0, "R8");
    step(7, 3, 0, 1, 1, 0, 0, "R8");
    step(7, 3, 0, 1, 0, 0, 0, "R8");
    step(7, 3, 0, 0, 1, 0, 0, "R8");

    // R9: bitwise tests; step triggers leave the register alone
    step(8, 8, 1, 0, 0, 8'h0C, 8'h04, "R9");
    step(8, 8, 0, 1, 1, 8'h00, 8'h03, "R9");
    step(8, 8, 0, 1, 0, 8'h00, 8'h08, "R9");
    step(9, 8, 1, 0, 0, 8'h00, 8'h00, "R9");
    step(9, 8, 0, 1, 1, 8'h00, 8'h00, "R9");
    step(9, 8, 0, 0, 0, 8'h00, 8'h40, "R9");

    // R10: majority-of-three shifter
    step(10, 8, 1, 0, 0, 8'h0F, 0, "R10");
    for (int i = 0; i < 4; i++) step(10, 8, 0, 1, 0, 0, 0, "R10");
    step(10, 8, 1, 0, 0, 8'h0C, 0, "R10");
    step(10, 8, 0, 1, 0, 0, 0, "R10");
    step(10, 8, 0, 1, 0, 0, 0, "R10");

    // R11: shift and compare
    step(11, 8, 1, 0, 0, 8'h00, 8'hC0, "R11");
    step(11, 8, 0, 1, 1, 8'h00, 8'hC0, "R11");
    step(11, 8, 0, 1, 1, 8'h00, 8'hC0, "R11");
    step(11, 8, 0, 1, 0, 8'h00, 8'hC0, "R11");

    // R12: size limits and out-of-range codes
    step(11, 4, 1, 0, 0, 8'hFF, 8'h0F, "R12");
    step(11, 0, 1, 0, 0, 8'h80, 8'h80, "R12");
    step(11, 12, 0, 1, 0, 8'h80, 8'h40, "R12");
    step(0, 1, 1, 0, 0, 8'h00, 8'hFF, "R12");
    step(0, 1, 0, 1, 0, 8'h00, 8'hFF, "R12");
    step(7, 2, 1, 0, 0, 8'hFE, 0, "R12");
    step(7, 2, 0, 1, 1, 8'h00, 0, "R12");
    step(7, 2, 0, 1, 0, 8'h00, 0, "R12");

    @(negedge clk);
    trig0 = 0; trig1 = 0; trig2 = 0;
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule